// File: doc/BRIEF.md
# Per-Timeslot Payload Loopback Selector

This block sits in the transmit serial path of a framed TDM line interface. Its frame holds 32 timeslots of 8 bits each, which is 256 bits per frame. For every timeslot it picks one of two sources for the outgoing serial bit. The first source is the transmit serial input coming from the backplane. The second is the received line stream for the same timeslot. A 32-bit channel mask makes the choice, so only the flagged 64 kbit/s channels in each frame are swapped for received payload. All other channels pass through untouched.

Both directions run from one bit clock and one frame-sync pulse, so the two streams stay aligned without any delay matching. The mask lives in four 8-bit enable registers that are written through a simple write port and read back through a combinational read port. A mask change is never applied in the middle of a byte. The output is registered once.

Top module: `tslot_loop_sel`

## Requirements
- R1: While `rst` is high and on the first cycle after it is released, `tx_out` is 0. All four enable registers read back 0 after reset, so no channel is looped.
- R2: Every bit of a channel whose enable bit is 1 is taken from `rx_in`.
- R3: Every bit of a channel whose enable bit is 0 is taken from `tx_in`.
- R4: The register mapping is fixed. The register at address 0x4B holds channels 1 to 8, 0x4C holds channels 9 to 16, 0x4D holds channels 17 to 24 and 0x4E holds channels 25 to 32. Bit j of the register at 0x4B+i enables channel 8*i+j+1, so bit 0 is the lowest channel of the group.
- R5: A one-cycle pulse on `fsync` marks the first bit of channel 1, and each channel then lasts 8 bit clocks. A pulse that arrives at any point restarts the frame at channel 1 on that same cycle.
- R6: A write that lands partway through a channel does not change the source of that channel's remaining bits. It takes effect from the first bit of the next channel that starts after the write.
- R7: The output lags the inputs by exactly one bit clock. A bit sampled on one rising edge appears on `tx_out` after that edge.
- R8: `rd_data` returns the current value of the enable register selected by `rd_addr`, with no clock delay. Every other address reads 0.
- R9: Any set of channels can be looped at the same time, from none to all 32, with adjacent and non-adjacent channels mixed.
- R10: Writes to addresses outside 0x4B to 0x4E change no register and do not affect the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared bit clock for both directions |
| rst | input | 1 | Synchronous active-high reset |
| fsync | input | 1 | One-cycle pulse on the first bit of channel 1 |
| tx_in | input | 1 | Transmit serial data from the backplane |
| rx_in | input | 1 | Received line serial data, aligned to the same sync |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 8 | Register read address |
| rd_data | output | 8 | Register read data, combinational |
| tx_out | output | 1 | Registered transmit serial output |

## Verification
A wrong bit counter or a stale held selection shows up on `tx_out` one bit clock after the affected bit. A channel then carries the wrong source, or it switches source partway through its byte. The bench drives `tx_in` and `rx_in` with streams that differ on almost every bit, so such an error appears within the first bit of the wrong channel. A register that is decoded wrongly shows at `rd_data` on the same cycle it is read. It also shows on `tx_out` when the first channel it controls next starts.

// File: rtl/tslot_loop_pkg.sv
package tslot_loop_pkg;

    // Default frame geometry and register window
    localparam int DEF_SLOTS     = 32;
    localparam int DEF_SLOT_BITS = 8;
    localparam int DEF_REG_W     = 8;
    localparam int DEF_ADDR_W    = 8;
    localparam logic [7:0] DEF_BASE_ADDR = 8'h4B;

    // Which stream feeds the output for the current timeslot
    typedef enum logic {
        SRC_TX = 1'b0,
        SRC_RX = 1'b1
    } src_sel_t;

    // Number of enable registers needed to cover all timeslots
    function automatic int reg_count(input int slots, input int reg_w);
        return (slots + reg_w - 1) / reg_w;
    endfunction

    // Bits in a full frame
    function automatic int frame_bits(input int slots, input int slot_bits);
        return slots * slot_bits;
    endfunction

    // Map a mask bit to a source selection
    function automatic src_sel_t to_src(input logic en);
        return en ? SRC_RX : SRC_TX;
    endfunction

endpackage

// File: rtl/tsl_frame_counter.sv
module tsl_frame_counter #(
    parameter int FRAME_LEN = 256,
    parameter int POS_W     = 8,
    parameter int LANE_W    = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             fsync,
    output logic [POS_W-1:0] pos,
    output logic             slot_start
);

    logic [POS_W-1:0] cnt;

    // The sync pulse marks bit zero of the frame on the cycle it is seen
    assign pos        = fsync ? '0 : cnt;
    assign slot_start = (pos[LANE_W-1:0] == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (pos == POS_W'(FRAME_LEN - 1)) begin
            cnt <= '0;
        end else begin
            cnt <= pos + 1'b1;
        end
    end

endmodule

// File: rtl/tsl_mask_regs.sv
module tsl_mask_regs #(
    parameter int               NREGS     = 4,
    parameter int               REG_W     = 8,
    parameter int               ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 8'h4B
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     wr_en,
    input  logic [ADDR_W-1:0]        wr_addr,
    input  logic [REG_W-1:0]         wr_data,
    input  logic [ADDR_W-1:0]        rd_addr,
    output logic [REG_W-1:0]         rd_data,
    output logic [NREGS*REG_W-1:0]   mask
);

    logic [REG_W-1:0] bank [NREGS];

    for (genvar g = 0; g < NREGS; g++) begin : g_reg
        localparam logic [ADDR_W-1:0] REG_ADDR = ADDR_W'(BASE_ADDR + g);

        always_ff @(posedge clk) begin
            if (rst) begin
                bank[g] <= '0;
            end else if (wr_en && (wr_addr == REG_ADDR)) begin
                bank[g] <= wr_data;
            end
        end

        // Bit j of register g enables timeslot g*REG_W + j
        assign mask[g*REG_W +: REG_W] = bank[g];
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NREGS; i++) begin
            if (rd_addr == ADDR_W'(BASE_ADDR + i)) begin
                rd_data = bank[i];
            end
        end
    end

endmodule

// File: rtl/tsl_src_select.sv
module tsl_src_select
    import tslot_loop_pkg::*;
#(
    parameter int SLOTS  = 32,
    parameter int SLOT_W = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              slot_start,
    input  logic [SLOT_W-1:0] slot,
    input  logic [SLOTS-1:0]  mask,
    input  logic              tx_in,
    input  logic              rx_in,
    output src_sel_t          src_now,
    output logic              tx_out
);

    src_sel_t src_held;

    // Sample the mask only on the first bit of a timeslot; hold it for the rest
    assign src_now = slot_start ? to_src(mask[slot]) : src_held;

    always_ff @(posedge clk) begin
        if (rst) begin
            src_held <= SRC_TX;
            tx_out   <= 1'b0;
        end else begin
            src_held <= src_now;
            tx_out   <= (src_now == SRC_RX) ? rx_in : tx_in;
        end
    end

endmodule

// File: rtl/tslot_loop_sel.sv
module tslot_loop_sel
    import tslot_loop_pkg::*;
#(
    parameter int          SLOTS     = DEF_SLOTS,
    parameter int          SLOT_BITS = DEF_SLOT_BITS,
    parameter int          REG_W     = DEF_REG_W,
    parameter int          ADDR_W    = DEF_ADDR_W,
    parameter logic [7:0]  BASE_ADDR = DEF_BASE_ADDR
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fsync,
    input  logic              tx_in,
    input  logic              rx_in,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [REG_W-1:0]  wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [REG_W-1:0]  rd_data,
    output logic              tx_out
);

    localparam int NREGS     = reg_count(SLOTS, REG_W);
    localparam int FRAME_LEN = frame_bits(SLOTS, SLOT_BITS);
    localparam int POS_W     = $clog2(FRAME_LEN);
    localparam int LANE_W    = $clog2(SLOT_BITS);
    localparam int SLOT_W    = POS_W - LANE_W;

    logic [POS_W-1:0]       pos;
    logic                   slot_start;
    logic [NREGS*REG_W-1:0] mask_all;
    src_sel_t               src_now;

    tsl_frame_counter #(
        .FRAME_LEN (FRAME_LEN),
        .POS_W     (POS_W),
        .LANE_W    (LANE_W)
    ) u_cnt (
        .clk        (clk),
        .rst        (rst),
        .fsync      (fsync),
        .pos        (pos),
        .slot_start (slot_start)
    );

    tsl_mask_regs #(
        .NREGS     (NREGS),
        .REG_W     (REG_W),
        .ADDR_W    (ADDR_W),
        .BASE_ADDR (ADDR_W'(BASE_ADDR))
    ) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .mask    (mask_all)
    );

    tsl_src_select #(
        .SLOTS  (SLOTS),
        .SLOT_W (SLOT_W)
    ) u_sel (
        .clk        (clk),
        .rst        (rst),
        .slot_start (slot_start),
        .slot       (pos[POS_W-1:LANE_W]),
        .mask       (mask_all[SLOTS-1:0]),
        .tx_in      (tx_in),
        .rx_in      (rx_in),
        .src_now    (src_now),
        .tx_out     (tx_out)
    );

endmodule

// File: rtl/tsl_loop_chk.sv
module tsl_loop_chk
    import tslot_loop_pkg::*;
#(
    parameter int POS_W  = 8,
    parameter int LANE_W = 3
) (
    input logic             clk,
    input logic             rst,
    input logic             fsync,
    input logic             tx_in,
    input logic             rx_in,
    input logic             tx_out,
    input logic [POS_W-1:0] pos,
    input src_sel_t         src_now
);

    assert_reset_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (tx_out == 1'b0));

    assert_loop_rx_R2: assert property (@(posedge clk) disable iff (rst)
        (src_now == SRC_RX) |=> (tx_out == $past(rx_in)));

    assert_pass_tx_R3: assert property (@(posedge clk) disable iff (rst)
        (src_now == SRC_TX) |=> (tx_out == $past(tx_in)));

    assert_sync_restart_R5: assert property (@(posedge clk) disable iff (rst)
        fsync |=> (fsync || (pos == POS_W'(1))));

    assert_no_split_R6: assert property (@(posedge clk) disable iff (rst)
        (pos[LANE_W-1:0] != '0) |-> $stable(src_now));

endmodule

bind tslot_loop_sel tsl_loop_chk #(
    .POS_W  (POS_W),
    .LANE_W (LANE_W)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .fsync   (fsync),
    .tx_in   (tx_in),
    .rx_in   (rx_in),
    .tx_out  (tx_out),
    .pos     (pos),
    .src_now (src_now)
);

// File: tb/tslot_loop_sel_test.sv
module tslot_loop_sel_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       fsync = 1'b0;
    logic       tx_in = 1'b0;
    logic       rx_in = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       tx_out;

    int checks = 0;
    int errors = 0;

    // Bench model state
    logic [31:0] m_mask = '0;
    logic        m_sel  = 1'b0;
    int          m_pos  = 0;
    logic        exp_prev = 1'b0;
    bit          have_prev = 1'b0;
    string       tag_prev = "";
    int          k = 0;

    always #10 clk = ~clk;  // 50 MHz

    tslot_loop_sel uut (
        .clk     (clk),
        .rst     (rst),
        .fsync   (fsync),
        .tx_in   (tx_in),
        .rx_in   (rx_in),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .tx_out  (tx_out)
    );

    function automatic logic gen_tx(input int n);
        return ^(32'(n * 29 + 7));
    endfunction

    function automatic logic gen_rx(input int n);
        return ~gen_tx(n) ^ ((n % 11) == 0);
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Model write decode for 0x4B..0x4E (R4, R10)
    task automatic model_write(input logic [7:0] a, input logic [7:0] d);
        if (a >= 8'h4B && a <= 8'h4E) m_mask[(a - 8'h4B) * 8 +: 8] = d;
    endtask

    // One bit clock: check the previous bit's output (R7) then drive the next
    task automatic step(input logic fs, input logic we, input logic [7:0] wa,
                        input logic [7:0] wd, input string tag);
        int p;
        @(negedge clk);
        if (have_prev) check({tag_prev, " bit out"}, {31'b0, tx_out}, {31'b0, exp_prev});
        fsync   = fs;
        tx_in   = gen_tx(k);
        rx_in   = gen_rx(k);
        wr_en   = we;
        wr_addr = wa;
        wr_data = wd;
        p = fs ? 0 : m_pos;
        if ((p % 8) == 0) m_sel = m_mask[p / 8];
        exp_prev  = m_sel ? rx_in : tx_in;
        tag_prev  = tag;
        have_prev = 1'b1;
        m_pos = (p == 255) ? 0 : p + 1;
        if (we) model_write(wa, wd);
        k++;
    endtask

    task automatic flush();
        @(negedge clk);
        if (have_prev) check({tag_prev, " bit out"}, {31'b0, tx_out}, {31'b0, exp_prev});
        have_prev = 1'b0;
        fsync = 1'b0;
        wr_en = 1'b0;
    endtask

    task automatic wr_reg(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        model_write(a, d);
    endtask

    task automatic rd_check(input logic [7:0] a, input logic [7:0] exp, input string tag);
        @(negedge clk);
        rd_addr = a;
        #1;
        check(tag, {24'b0, rd_data}, {24'b0, exp});
    endtask

    // A frame with an optional mid-frame write at bit wbit and optional resync at rbit
    task automatic run_frame(input string tag, input int wbit, input logic [7:0] wa,
                             input logic [7:0] wd, input int rbit, input int nbits);
        for (int b = 0; b < nbits; b++) begin
            step((b == 0) || (b == rbit), (b == wbit), wa, wd, tag);
        end
        flush();
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        check("R1 tx_out in reset", {31'b0, tx_out}, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 tx_out after reset", {31'b0, tx_out}, 32'd0);
        for (int i = 0; i < 4; i++) rd_check(8'(8'h4B + i), 8'h00, "R1 register reset value");
    endtask

    task automatic t_readback();
        wr_reg(8'h4B, 8'hA5);
        wr_reg(8'h4C, 8'h3C);
        wr_reg(8'h4D, 8'h81);
        wr_reg(8'h4E, 8'h7E);
        rd_check(8'h4B, 8'hA5, "R8 readback 0x4B");
        rd_check(8'h4C, 8'h3C, "R8 readback 0x4C");
        rd_check(8'h4D, 8'h81, "R8 readback 0x4D");
        rd_check(8'h4E, 8'h7E, "R8 readback 0x4E");
        wr_reg(8'h4A, 8'hFF);
        wr_reg(8'h4F, 8'hFF);
        rd_check(8'h4A, 8'h00, "R8 unmapped read 0x4A");
        rd_check(8'h4F, 8'h00, "R8 unmapped read 0x4F");
        rd_check(8'h4B, 8'hA5, "R10 0x4B unchanged by stray write");
        rd_check(8'h4E, 8'h7E, "R10 0x4E unchanged by stray write");
    endtask

    task automatic set_mask(input logic [31:0] m);
        for (int i = 0; i < 4; i++) wr_reg(8'(8'h4B + i), m[i*8 +: 8]);
    endtask

    task automatic t_none();
        set_mask(32'h0);
        run_frame("R3 all channels pass", -1, 8'h0, 8'h0, -1, 256);
    endtask

    task automatic t_all();
        set_mask(32'hFFFF_FFFF);
        run_frame("R2 R9 all channels looped", -1, 8'h0, 8'h0, -1, 256);
    endtask

    task automatic t_map();
        // channels 1, 8, 9, 32 -> slots 0, 7, 8, 31
        set_mask(32'h8000_0181);
        run_frame("R4 edge channel mapping", -1, 8'h0, 8'h0, -1, 256);
        set_mask(32'h5A0F_F0A5);
        run_frame("R9 mixed pattern", -1, 8'h0, 8'h0, -1, 256);
    endtask

    task automatic t_midwrite();
        set_mask(32'h0);
        // bit 100 is slot 12 lane 4; 0x30 to 0x4C enables slots 12 and 13
        run_frame("R6 mid-slot write", 100, 8'h4C, 8'h30, -1, 256);
        run_frame("R6 next frame uses new mask", -1, 8'h0, 8'h0, -1, 256);
        // stray write in the stream must not alter the output
        run_frame("R10 stray write mid-frame", 40, 8'h50, 8'hFF, -1, 256);
    endtask

    task automatic t_resync();
        set_mask(32'h0000_00F3);
        run_frame("R5 early frame sync", -1, 8'h0, 8'h0, 51, 320);
    endtask

    initial begin
        #(200000 * 20);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_readback();
        t_none();
        t_all();
        t_map();
        t_midwrite();
        t_resync();
        repeat (2) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule